// File: doc/BRIEF.md
# Serial Program Image Loader

This block takes a byte stream (one byte per cycle while `in_valid` is high, typically the output of a UART receiver) and turns it into writes into a 12-bit-wide program memory. It first searches the stream for a fixed six-byte sync pattern. It then reads a 16-bit word count, and then that many two-byte program words. Each word's low 12 bits go out on the memory write port, one write per word, at consecutive addresses starting at zero.

A trailing 16-bit checksum closes the image. The loader keeps a running sum of every byte after the sync pattern and before the checksum field, and compares it with the trailing field. It then reports success with a one-cycle `done` pulse, or failure with `csum_err`. A word whose top nibble is non-zero is rejected and flags the whole load as failed. After the checksum field the loader goes back to searching for the next sync pattern.

Top module: `img_loader`

## Requirements
- R1: No memory write, length or word is taken until the bytes 00, FF, 00, FF, A5, C3 have arrived consecutively in that order. Bytes before that produce no write and no `done`.
- R2: A byte that breaks a partial sync match restarts the search. If the breaking byte is 00 it counts as the first sync byte. When at least one sync byte had matched, the break raises `hdr_err` for one cycle.
- R3: The two bytes after the sync pattern form the word count. The first byte is bits 7:0 and the second byte is bits 15:8.
- R4: Each program word arrives low byte first. On its second byte the loader pulses `mem_we` for one cycle with `mem_wdata` = word bits 11:0. Words go to addresses 0, 1, 2, … in arrival order.
- R5: A word with a non-zero value in bits 15:12 is not written, but the address still advances past it. It sets `fmt_err`, which stays high until the next complete sync pattern, and it suppresses `done` for that image.
- R6: The checksum is the sum, modulo 65536, of the two count bytes and all word bytes; sync bytes are excluded. The trailing field is sent low byte first.
- R7: On the last checksum byte, if the field matches and `fmt_err` is low, `done` pulses for one cycle. If the field does not match, `csum_err` pulses for one cycle and `done` stays low.
- R8: A word count of zero makes the next two bytes the checksum field, with no memory write.
- R9: While `in_valid` is low the input byte is ignored and `mem_we`, `done` and `csum_err` stay low.
- R10: After the checksum field the loader searches for a new sync pattern, and the next image writes again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Program memory write address |
| mem_wdata | output | 12 | Instruction word to write |
| done | output | 1 | One-cycle pulse: image loaded and verified |
| hdr_err | output | 1 | One-cycle pulse: partial sync match broken |
| csum_err | output | 1 | One-cycle pulse: checksum field mismatch |
| fmt_err | output | 1 | Level: a word in the current image had a non-zero top nibble |

## Verification
A clean three-word image with mixed nibble values shows that word assembly, address order and checksum agreement are correct. Junk bytes that hold a partial sync prefix, and a repeated 00, show whether the restart rule counts a breaking 00 as the first sync byte. A zero-length image, an image with a corrupted checksum and an image with one bad top nibble separate the three ways a load can end: a clean end, a checksum failure and a format failure. Idle gaps carrying 00 on the data lines, followed by a second back-to-back image, show that idle cycles are ignored and that the address starts again from zero.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;

    typedef enum logic [2:0] {
        LD_SYNC,
        LD_CNT_LO,
        LD_CNT_HI,
        LD_W_LO,
        LD_W_HI,
        LD_CK_LO,
        LD_CK_HI
    } ld_state_e;

    localparam int SYNC_LEN = 6;

    function automatic logic [7:0] sync_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    sync_byte = 8'h00;
            3'd1:    sync_byte = 8'hFF;
            3'd2:    sync_byte = 8'h00;
            3'd3:    sync_byte = 8'hFF;
            3'd4:    sync_byte = 8'hA5;
            default: sync_byte = 8'hC3;
        endcase
    endfunction

endpackage

// File: rtl/sync_match.sv
module sync_match
    import img_loader_pkg::*;
(
    input  logic [2:0] idx,
    input  logic [7:0] byt,
    output logic [2:0] idx_nxt,
    output logic       complete,
    output logic       broke
);
    always_comb begin
        complete = 1'b0;
        broke    = 1'b0;
        idx_nxt  = 3'd0;
        if (byt == sync_byte(idx)) begin
            if (idx == 3'(SYNC_LEN - 1)) begin
                complete = 1'b1;
            end else begin
                idx_nxt = idx + 3'd1;
            end
        end else begin
            broke   = (idx != 3'd0);
            idx_nxt = (byt == sync_byte(3'd0)) ? 3'd1 : 3'd0;
        end
    end
endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [7:0]   byt,
    output logic [W-1:0] sum
);
    logic [W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add) begin
            sum_d = sum_q + W'(byt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/word_pack.sv
module word_pack #(
    parameter int IW = 12
) (
    input  logic [7:0]    lo,
    input  logic [7:0]    hi,
    output logic [IW-1:0] insn,
    output logic          bad
);
    localparam int FW = 16;
    logic [FW-1:0] full;

    always_comb begin
        full = {hi, lo};
        insn = full[IW-1:0];
        bad  = |full[FW-1:IW];
    end
endmodule

// File: rtl/img_loader.sv
module img_loader
    import img_loader_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IW-1:0]     mem_wdata,
    output logic              done,
    output logic              hdr_err,
    output logic              csum_err,
    output logic              fmt_err
);
    localparam int CW = 16;

    typedef struct packed {
        ld_state_e         st;
        logic [2:0]        hidx;
        logic [CW-1:0]     left;
        logic [7:0]        lo;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] waddr;
        logic              we;
        logic [IW-1:0]     wdata;
        logic              done;
        logic              cerr;
        logic              herr;
        logic              ferr;
    } ld_regs_t;

    ld_regs_t r_d, r_q;

    logic [2:0]    m_idx;
    logic          m_complete, m_broke;
    logic          ck_clr, ck_add;
    logic [CW-1:0] ck_sum;
    logic [IW-1:0] w_insn;
    logic          w_bad;
    logic [CW-1:0] hi_lo;

    sync_match u_sync (
        .idx      (r_q.hidx),
        .byt      (in_byte),
        .idx_nxt  (m_idx),
        .complete (m_complete),
        .broke    (m_broke)
    );

    csum_acc #(.W(CW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ck_clr),
        .add   (ck_add),
        .byt   (in_byte),
        .sum   (ck_sum)
    );

    word_pack #(.IW(IW)) u_pack (
        .lo   (r_q.lo),
        .hi   (in_byte),
        .insn (w_insn),
        .bad  (w_bad)
    );

    assign hi_lo = {in_byte, r_q.lo};

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        r_d.cerr = 1'b0;
        r_d.herr = 1'b0;
        ck_clr   = 1'b0;
        ck_add   = 1'b0;
        if (in_valid) begin
            case (r_q.st)
                LD_SYNC: begin
                    r_d.hidx = m_idx;
                    r_d.herr = m_broke;
                    if (m_complete) begin
                        r_d.st   = LD_CNT_LO;
                        r_d.ferr = 1'b0;
                        r_d.addr = '0;
                        ck_clr   = 1'b1;
                    end
                end
                LD_CNT_LO: begin
                    r_d.lo = in_byte;
                    ck_add = 1'b1;
                    r_d.st = LD_CNT_HI;
                end
                LD_CNT_HI: begin
                    ck_add   = 1'b1;
                    r_d.left = hi_lo;
                    r_d.st   = (hi_lo == '0) ? LD_CK_LO : LD_W_LO;
                end
                LD_W_LO: begin
                    r_d.lo = in_byte;
                    ck_add = 1'b1;
                    r_d.st = LD_W_HI;
                end
                LD_W_HI: begin
                    ck_add = 1'b1;
                    if (w_bad) begin
                        r_d.ferr = 1'b1;
                    end else begin
                        r_d.we    = 1'b1;
                        r_d.wdata = w_insn;
                        r_d.waddr = r_q.addr;
                    end
                    r_d.addr = r_q.addr + ADDR_W'(1);
                    r_d.left = r_q.left - CW'(1);
                    r_d.st   = (r_q.left == CW'(1)) ? LD_CK_LO : LD_W_LO;
                end
                LD_CK_LO: begin
                    r_d.lo = in_byte;
                    r_d.st = LD_CK_HI;
                end
                LD_CK_HI: begin
                    if (hi_lo == ck_sum) begin
                        r_d.done = ~r_q.ferr;
                    end else begin
                        r_d.cerr = 1'b1;
                    end
                    r_d.hidx = 3'd0;
                    r_d.st   = LD_SYNC;
                end
                default: begin
                    r_d.st   = LD_SYNC;
                    r_d.hidx = 3'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: LD_SYNC, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.waddr;
    assign mem_wdata = r_q.wdata;
    assign done      = r_q.done;
    assign hdr_err   = r_q.herr;
    assign csum_err  = r_q.cerr;
    assign fmt_err   = r_q.ferr;
endmodule

// File: rtl/img_loader_chk.sv
module img_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic mem_we,
    input logic done,
    input logic csum_err,
    input logic fmt_err
);
    // R7: a load never ends both verified and failed
    p_end_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && csum_err));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a load flagged for format cannot report success
    p_fmt_blocks_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fmt_err);

    // R9: an idle input cycle produces no write or end pulse
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!mem_we && !done && !csum_err));

    // R4: each word takes two bytes, so writes never come back to back
    p_write_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind img_loader img_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mem_we   (mem_we),
    .done     (done),
    .csum_err (csum_err),
    .fmt_err  (fmt_err)
);

// File: tb/sim_img_loader.sv
module sim_img_loader;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              mem_we, done, hdr_err, csum_err, fmt_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [11:0]       mem_wdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int wr_cnt, done_cnt, cerr_cnt, herr_cnt;
    logic [ADDR_W-1:0] log_addr [0:15];
    logic [11:0]       log_data [0:15];
    logic [15:0]       img_w    [0:15];

    always #10 clk = ~clk;

    img_loader #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .hdr_err(hdr_err), .csum_err(csum_err), .fmt_err(fmt_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (wr_cnt < 16) begin
                    log_addr[wr_cnt] = mem_addr;
                    log_data[wr_cnt] = mem_wdata;
                end
                wr_cnt++;
            end
            if (done)     done_cnt++;
            if (csum_err) cerr_cnt++;
            if (hdr_err)  herr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        in_valid = 1'b0;
        wr_cnt = 0; done_cnt = 0; cerr_cnt = 0; herr_cnt = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'h00;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_sync(input int gap);
        send_byte(8'h00, gap); send_byte(8'hFF, gap); send_byte(8'h00, gap);
        send_byte(8'hFF, gap); send_byte(8'hA5, gap); send_byte(8'hC3, gap);
    endtask

    task automatic send_image(input int n, input bit corrupt, input int gap);
        logic [15:0] s;
        logic [15:0] len;
        len = 16'(n);
        send_sync(gap);
        s = 16'(len[7:0]) + 16'(len[15:8]);
        send_byte(len[7:0], gap);
        send_byte(len[15:8], gap);
        for (int i = 0; i < n; i++) begin
            s = s + 16'(img_w[i][7:0]) + 16'(img_w[i][15:8]);
            send_byte(img_w[i][7:0], gap);
            send_byte(img_w[i][15:8], gap);
        end
        if (corrupt) s = s ^ 16'h0001;
        send_byte(s[7:0], gap);
        send_byte(s[15:8], gap);
        idle(3);
    endtask

    task automatic t_reset();
        chk(!mem_we && !done && !csum_err && !hdr_err && !fmt_err, "R9",
            "outputs after reset",
            int'({mem_we, done, csum_err, hdr_err, fmt_err}), 0);
    endtask

    task automatic t_basic();
        clear_counts();
        img_w[0] = 16'h0123; img_w[1] = 16'h0ABC; img_w[2] = 16'h00FF;
        send_image(3, 1'b0, 0);
        chk(wr_cnt == 3, "R4", "write count", wr_cnt, 3);
        for (int i = 0; i < 3; i++) begin
            chk(log_addr[i] == ADDR_W'(i), "R4", "address", int'(log_addr[i]), i);
            chk(log_data[i] == img_w[i][11:0], "R4", "data",
                int'(log_data[i]), int'(img_w[i][11:0]));
        end
        chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        chk(cerr_cnt == 0, "R6", "csum_err on good image", cerr_cnt, 0);
    endtask

    task automatic t_junk_restart();
        clear_counts();
        // junk with no partial match: no hdr_err
        send_byte(8'hA5, 0); send_byte(8'h12, 0);
        // partial match broken at fourth byte
        send_byte(8'h00, 0); send_byte(8'hFF, 0); send_byte(8'h00, 0);
        send_byte(8'h11, 0);
        // 00 00 : second 00 breaks the match but counts as first sync byte
        send_byte(8'h00, 0);
        send_byte(8'h00, 0); send_byte(8'hFF, 0); send_byte(8'h00, 0);
        send_byte(8'hFF, 0); send_byte(8'hA5, 0);
        idle(2);
        chk(wr_cnt == 0 && done_cnt == 0, "R1", "activity before sync",
            wr_cnt + done_cnt, 0);
        chk(herr_cnt == 2, "R2", "hdr_err pulses", herr_cnt, 2);
        // finish the pending sync with C3, then a one-word body 0x0456
        send_byte(8'hC3, 0);
        send_byte(8'h01, 0); send_byte(8'h00, 0);
        send_byte(8'h56, 0); send_byte(8'h04, 0);
        send_byte(8'h5B, 0); send_byte(8'h00, 0);
        idle(3);
        chk(wr_cnt == 1 && log_data[0] == 12'h456, "R2", "word after 00 restart",
            int'(log_data[0]), 'h456);
        chk(done_cnt == 1, "R3", "done with LE count", done_cnt, 1);
    endtask

    task automatic t_zero_len();
        clear_counts();
        send_image(0, 1'b0, 0);
        chk(wr_cnt == 0, "R8", "writes for zero count", wr_cnt, 0);
        chk(done_cnt == 1, "R8", "done for zero count", done_cnt, 1);
    endtask

    task automatic t_bad_csum();
        clear_counts();
        img_w[0] = 16'h0777; img_w[1] = 16'h0001;
        send_image(2, 1'b1, 0);
        chk(cerr_cnt == 1, "R7", "csum_err on corrupt field", cerr_cnt, 1);
        chk(done_cnt == 0, "R7", "done on corrupt field", done_cnt, 0);
    endtask

    task automatic t_bad_nibble();
        clear_counts();
        img_w[0] = 16'h0111; img_w[1] = 16'h1222; img_w[2] = 16'h0333;
        send_image(3, 1'b0, 0);
        chk(wr_cnt == 2, "R5", "writes with bad word", wr_cnt, 2);
        chk(log_addr[1] == ADDR_W'(2) && log_data[1] == 12'h333, "R5",
            "address skips bad word", int'(log_addr[1]), 2);
        chk(fmt_err == 1'b1, "R5", "fmt_err level", int'(fmt_err), 1);
        chk(done_cnt == 0 && cerr_cnt == 0, "R5", "done/csum_err with bad word",
            done_cnt + cerr_cnt, 0);
        send_sync(0);
        idle(1);
        chk(fmt_err == 1'b0, "R5", "fmt_err cleared by new sync", int'(fmt_err), 0);
        send_byte(8'h00, 0); send_byte(8'h00, 0);
        send_byte(8'h00, 0); send_byte(8'h00, 0);
        idle(3);
    endtask

    task automatic t_gaps_and_restart();
        clear_counts();
        img_w[0] = 16'h0FED; img_w[1] = 16'h0C0B;
        send_image(2, 1'b0, 2);
        chk(wr_cnt == 2 && log_data[1] == 12'hC0B, "R9", "image with idle gaps",
            int'(log_data[1]), 'hC0B);
        chk(done_cnt == 1, "R9", "done with idle gaps", done_cnt, 1);
        clear_counts();
        img_w[0] = 16'h0999;
        send_image(1, 1'b0, 0);
        chk(wr_cnt == 1 && log_addr[0] == '0, "R10", "second image address",
            int'(log_addr[0]), 0);
        chk(done_cnt == 1, "R10", "second image done", done_cnt, 1);
        chk(log_data[0] == 12'h999, "R6", "second image data", int'(log_data[0]), 'h999);
    endtask

    initial begin
        wr_cnt = 0; done_cnt = 0; cerr_cnt = 0; herr_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_junk_restart();
        t_zero_len();
        t_bad_csum();
        t_bad_nibble();
        t_gaps_and_restart();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule